// File: doc/BRIEF.md
# Three-Channel Watchdog Timer Block

This block holds three independent watchdog channels behind one small memory-mapped register port. Each channel owns a 16-bit down-counter, a limit register and a status byte. A shared prescaler divides the system clock into a single-cycle tick every tenth of a second, and the counters step down only on that tick. Software starts a channel by writing its limit, and keeps it alive by reading its counter, which reloads the counter from the limit.

Each channel drives one kind of action when it runs out. Channel 0 raises an interrupt level, channel 1 emits a CPU reset pulse and channel 2 emits a board-wide reset pulse. A shared mask register can suppress the action of any channel, but its counter keeps running and still reports expiry in its status. The bus bridge, the interrupt controller and the reset distribution lie outside this block.

Top module: `wdt_trio`

## Requirements
- R1: After reset every channel's counter and limit read 1, every status reads 0, the mask reads 0, and irq_o, cpu_rst_o and sys_rst_o are low.
- R2: Address bits [5:4] select the block (0, 1, 2 = channel, 3 = mask) and bits [3:2] the register (0 = counter, 1 = limit, 2 = status). The mask sits at 0x30. A read request returns its data on rdata_o in the next cycle. Unmapped offsets and cycles without a read give 0.
- R3: The prescaler raises a tick once every CLK_HZ/TICK_HZ cycles, the first tick coming that many cycles after reset. A counter changes on a tick only while its channel is running, and otherwise only through a bus access.
- R4: A write to a channel's limit loads both limit and counter with the written value, sets running, and clears expired, even when the channel is already running.
- R5: A counter read returns the value held before the access and reloads the counter from the limit. Running and expired do not change. A limit read changes nothing.
- R6: On a tick, a running channel whose counter is 0 or 1 sets its counter to 0, clears running and sets expired. It stays expired until its limit is written again. Writes to the counter or status offsets are ignored.
- R7: Status reads return running in bit 0 and expired in bit 1, with all other bits 0. Running and expired are never set together.
- R8: Mask bits 0, 1 and 2 belong to channels 0, 1 and 2. A 1 suppresses that channel's action. Writes keep bits [2:0], reads return them with the upper bits 0, and masked counters keep counting and expiring.
- R9: irq_o is high exactly while channel 0 is expired and mask bit 0 is 0.
- R10: When channel 1 expires with mask bit 1 at 0 in that cycle, cpu_rst_o goes high in the next cycle for RST_CYCLES cycles. Expiry under the mask, or clearing the mask later, gives no pulse.
- R11: Channel 2 drives sys_rst_o by the same rule as R10, using mask bit 2.
- R12: In the cycle of a tick, a limit write or a counter read to a channel takes precedence over its decrement or expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, one cycle after the request |
| irq_o | output | 1 | Interrupt level from channel 0 |
| cpu_rst_o | output | 1 | CPU reset pulse from channel 1 |
| sys_rst_o | output | 1 | Board reset pulse from channel 2 |

## Verification
The bench builds the block with CLK_HZ = 40 and TICK_HZ = 10, so a tick arrives every 4 cycles. It also sets RST_CYCLES = 3, so a reset pulse is shorter than one tick period. With these values, limits of 0 to 6 expire within a few dozen cycles. Random reloads, restarts and mask changes can then land on the same cycle as a tick, an expiry or an active reset pulse, and thousands of such collisions fit in a short run.

// File: rtl/wdt_trio_pkg.sv
package wdt_trio_pkg;
  localparam int NCH = 3;
  localparam int CW  = 16;
  localparam int AW  = 6;

  typedef enum logic [1:0] {
    REG_CNT  = 2'd0,
    REG_LIM  = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam logic [1:0] MASK_BLK = 2'd3;
  localparam int ST_RUN = 0;
  localparam int ST_EXP = 1;
endpackage

// File: rtl/wdt_presc.sv
module wdt_presc #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdt_chan.sv
module wdt_chan #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          lim_wr_i,
  input  logic          cnt_rd_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] lim_o,
  output logic          run_o,
  output logic          exp_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q, lim_q;
  logic          run_q, exp_q;

  // bus access wins over the tick
  assign expire_o = tick_i & run_q & (cnt_q < CW'(2)) & ~lim_wr_i & ~cnt_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(1);
      lim_q <= CW'(1);
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else if (lim_wr_i) begin
      cnt_q <= wdata_i;
      lim_q <= wdata_i;
      run_q <= 1'b1;
      exp_q <= 1'b0;
    end else if (cnt_rd_i) begin
      cnt_q <= lim_q;
    end else if (expire_o) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b1;
    end else if (tick_i && run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign lim_o = lim_q;
  assign run_o = run_q;
  assign exp_o = exp_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int PW = $clog2(LEN + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (trig_i)          left_q <= PW'(LEN);
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/wdt_trio.sv
module wdt_trio
  import wdt_trio_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int TICK_HZ    = 10,
  parameter int RST_CYCLES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  output logic          irq_o,
  output logic          cpu_rst_o,
  output logic          sys_rst_o
);
  localparam int DIV = CLK_HZ / TICK_HZ;

  logic                   tick;
  logic [1:0]             blk;
  reg_sel_e               rsel;
  logic [NCH-1:0]         lim_wr, cnt_rd, run_v, exp_v, expire_v;
  logic [NCH-1:0][CW-1:0] cnt_v, lim_v;
  logic [NCH-1:0]         mask_q;
  logic [NCH-1:0]         act_v;
  logic [CW-1:0]          rd_d;

  assign blk  = addr_i[5:4];
  assign rsel = reg_sel_e'(addr_i[3:2]);

  wdt_presc #(.DIV(DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign lim_wr[i] = req_i &  we_i & (blk == 2'(i)) & (rsel == REG_LIM);
    assign cnt_rd[i] = req_i & ~we_i & (blk == 2'(i)) & (rsel == REG_CNT);

    wdt_chan #(.CW(CW)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .lim_wr_i (lim_wr[i]),
      .cnt_rd_i (cnt_rd[i]),
      .wdata_i  (wdata_i),
      .cnt_o    (cnt_v[i]),
      .lim_o    (lim_v[i]),
      .run_o    (run_v[i]),
      .exp_o    (exp_v[i]),
      .expire_o (expire_v[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      mask_q <= '0;
    else if (req_i && we_i && blk == MASK_BLK && rsel == REG_CNT)
      mask_q <= wdata_i[NCH-1:0];
  end

  always_comb begin
    rd_d = '0;
    if (req_i && !we_i) begin
      if (blk == MASK_BLK) begin
        if (rsel == REG_CNT) rd_d = CW'(mask_q);
      end else begin
        case (rsel)
          REG_CNT:  rd_d = cnt_v[blk];
          REG_LIM:  rd_d = lim_v[blk];
          REG_STAT: begin
            rd_d[ST_RUN] = run_v[blk];
            rd_d[ST_EXP] = exp_v[blk];
          end
          default:  rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_d;
  end

  // channel 0: level; channels 1, 2: timed pulses
  assign act_v[0] = exp_v[0] & ~mask_q[0];
  for (genvar i = 1; i < NCH; i++) begin : g_rst
    wdt_pulse #(.LEN(RST_CYCLES)) u_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .trig_i  (expire_v[i] & ~mask_q[i]),
      .pulse_o (act_v[i])
    );
  end

  assign irq_o     = act_v[0];
  assign cpu_rst_o = act_v[1];
  assign sys_rst_o = act_v[2];
endmodule

// File: rtl/wdt_trio_chk.sv
module wdt_trio_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        tick,
  input logic [2:0]  run_v,
  input logic [2:0]  exp_v,
  input logic [2:0]  mask_q,
  input logic [15:0] cnt0,
  input logic        irq_o,
  input logic        cpu_rst_o,
  input logic        sys_rst_o
);
  // R7
  run_exp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_v & exp_v) == 3'b000);

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !req_i) |=> $stable(cnt0));

  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($rose(exp_v[0]) || $fell(mask_q[0])));

  // R10
  cpu_pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_o) |-> ($rose(exp_v[1]) && !$past(mask_q[1])));

  // R11
  sys_pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> ($rose(exp_v[2]) && !$past(mask_q[2])));

  // R6
  exp_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_v[0] && !req_i) |=> exp_v[0]);
endmodule

bind wdt_trio wdt_trio_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .tick      (tick),
  .run_v     (run_v),
  .exp_v     (exp_v),
  .mask_q    (mask_q),
  .cnt0      (cnt_v[0]),
  .irq_o     (irq_o),
  .cpu_rst_o (cpu_rst_o),
  .sys_rst_o (sys_rst_o)
);

// File: tb/test_wdt_trio.sv
module test_wdt_trio;
  localparam int CLK_HZ = 40;
  localparam int TICK_HZ = 10;
  localparam int DIV = CLK_HZ / TICK_HZ;
  localparam int RSTC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, cpu_rst, sys_rst;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  int m_cnt[3], m_lim[3], m_pul[3];
  bit m_run[3], m_exp[3];
  int m_mask, m_pc, m_rd;
  string m_tag;

  always #4 clk = ~clk;

  wdt_trio #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .RST_CYCLES(RSTC)) i_wdt_trio (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .cpu_rst_o(cpu_rst),
    .sys_rst_o(sys_rst)
  );

  function automatic int rd_val(int b, int r);
    if (b == 3) return (r == 0) ? m_mask : 0;
    case (r)
      0: return m_cnt[b];
      1: return m_lim[b];
      2: return (int'(m_exp[b]) << 1) | int'(m_run[b]);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int b, int r);
    if (b == 3) return (r == 0) ? "R8" : "R2";
    case (r)
      0: return "R3 R5 R6 R12";
      1: return "R4 R5";
      2: return "R6 R7";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = 1; m_lim[i] = 1; m_run[i] = 0; m_exp[i] = 0; m_pul[i] = 0;
      end
      m_mask = 0; m_pc = 0; m_rd = 0; m_tag = "R1";
    end else begin
      bit tk;
      int b, r, nrd;
      tk = (m_pc == DIV - 1);
      b = int'(addr[5:4]); r = int'(addr[3:2]);
      nrd = 0;
      if (req && !we) begin
        nrd = rd_val(b, r);
        m_tag = tag_of(b, r);
      end else m_tag = "R2";
      for (int i = 0; i < 3; i++) begin
        bit evt;
        evt = 0;
        if (req && we && b == i && r == 1) begin
          m_lim[i] = int'(wdata); m_cnt[i] = int'(wdata); m_run[i] = 1; m_exp[i] = 0;
        end else if (req && !we && b == i && r == 0) begin
          m_cnt[i] = m_lim[i];
        end else if (tk && m_run[i]) begin
          if (m_cnt[i] < 2) begin
            m_cnt[i] = 0; m_run[i] = 0; m_exp[i] = 1; evt = 1;
          end else m_cnt[i] = m_cnt[i] - 1;
        end
        if (i > 0) begin
          if (evt && !m_mask[i]) m_pul[i] = RSTC;
          else if (m_pul[i] > 0) m_pul[i] = m_pul[i] - 1;
        end
      end
      if (req && we && b == 3 && r == 0) m_mask = int'(wdata[2:0]);
      m_pc = tk ? 0 : m_pc + 1;
      m_rd = nrd;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit ei;
    ei = m_exp[0] && !m_mask[0];
    chk(int'(rdata) == m_rd, {"rdata ", m_tag}, int'(rdata), m_rd);
    chk(irq == ei, "irq R9", int'(irq), int'(ei));
    chk(cpu_rst == (m_pul[1] > 0), "cpu_rst R10", int'(cpu_rst), int'(m_pul[1] > 0));
    chk(sys_rst == (m_pul[2] > 0), "sys_rst R11", int'(sys_rst), int'(m_pul[2] > 0));
  endtask

  task automatic op(bit rq, bit w, logic [5:0] a, logic [15:0] d);
    req = rq; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    check_all();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) op(0, 0, 6'h00, 16'h0);
  endtask

  task automatic wait_tick();
    while (m_pc != DIV - 1) idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all();
    // R1: reset values
    chk(irq == 0 && cpu_rst == 0 && sys_rst == 0, "R1 outputs", int'({irq, cpu_rst, sys_rst}), 0);
    op(1, 0, 6'h00, 0); chk(rdata == 16'd1, "R1 cnt0", int'(rdata), 1);
    op(1, 0, 6'h14, 0); chk(rdata == 16'd1, "R1 lim1", int'(rdata), 1);
    op(1, 0, 6'h28, 0); chk(rdata == 16'd0, "R1 stat2", int'(rdata), 0);
    op(1, 0, 6'h30, 0); chk(rdata == 16'd0, "R1 mask", int'(rdata), 0);
    // R4, R9: start ch0 with limit 2, let it expire
    op(1, 1, 6'h04, 16'd2);
    op(1, 0, 6'h08, 0); chk(rdata == 16'd1, "R4 running", int'(rdata), 1);
    idle(12);
    chk(irq == 1, "R9 irq set", int'(irq), 1);
    op(1, 0, 6'h08, 0); chk(rdata == 16'd2, "R6 expired", int'(rdata), 2);
    // R6: counter write ignored
    op(1, 1, 6'h00, 16'd9);
    op(1, 0, 6'h08, 0); chk(rdata == 16'd2, "R6 still expired", int'(rdata), 2);
    // R8: mask drops irq
    op(1, 1, 6'h30, 16'hFFF9);
    op(1, 0, 6'h30, 0); chk(rdata == 16'd1, "R8 mask readback", int'(rdata), 1);
    chk(irq == 0, "R8 irq masked", int'(irq), 0);
    // R10: ch1 unmasked pulse
    op(1, 1, 6'h14, 16'd1);
    idle(10);
    // R11: ch2 masked, no pulse; counter still expires
    op(1, 1, 6'h30, 16'd4);
    op(1, 1, 6'h24, 16'd1);
    idle(10);
    chk(sys_rst == 0, "R11 masked no pulse", int'(sys_rst), 0);
    op(1, 0, 6'h28, 0); chk(rdata == 16'd2, "R8 masked expires", int'(rdata), 2);
    op(1, 1, 6'h30, 16'd0);
    idle(3);
    chk(sys_rst == 0, "R11 late unmask", int'(sys_rst), 0);
    // R11: unmasked ch2 pulse
    op(1, 1, 6'h24, 16'd1);
    idle(10);
    // R12: limit write on a tick cycle
    wait_tick();
    op(1, 1, 6'h04, 16'd5);
    op(1, 0, 6'h00, 0); chk(rdata == 16'd5, "R12 write beats tick", int'(rdata), 5);
    op(1, 1, 6'h04, 16'd1);
    wait_tick();
    op(1, 0, 6'h00, 0); chk(rdata == 16'd1, "R12 read beats expiry", int'(rdata), 1);
    op(1, 0, 6'h08, 0); chk(rdata == 16'd1, "R12 still running", int'(rdata), 1);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      int s;
      logic [5:0] a;
      s = int'($urandom % 16);
      a = {2'($urandom % 4), 2'($urandom % 4), 2'b00};
      if (s < 8) idle(1);
      else if (s < 12) op(1, 0, a, 0);
      else if (s < 14) op(1, 1, {2'($urandom % 3), 4'h4}, 16'($urandom % 7));
      else if (s == 14) op(1, 1, 6'h30, 16'($urandom % 8));
      else op(1, 1, a, 16'($urandom));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule